// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged Receive Queue

This block recovers asynchronous serial characters from a single receive line using a tick that pulses sixteen times per bit period. A falling edge is confirmed half a bit later so that short glitches do not start a frame. After a confirmed start, every data bit, the optional parity bit and the stop bit are each sampled once at their bit centre. Characters of 5 to 8 bits are supported, with even, odd or no parity. Each finished character goes into a 16-entry first-in first-out queue. Three status flags travel with it: parity error, framing error and line break.

The head of the queue is always visible on the read outputs. A one-cycle read strobe removes it. If a character completes while the queue is full, that character is dropped, the queue is left unchanged and a sticky overrun flag is set. When automatic flow control is enabled, the request-to-send output drops once the fill level reaches a selectable threshold and rises again only after the queue has been emptied.

The frame engine has these states. IDLE waits for a low line on a tick. START_CHK counts 8 ticks and goes back to IDLE on a false start, or on to DATA. DATA collects bits and goes to PARITY when parity is enabled, otherwise to STOP. PARITY always goes to STOP. STOP pushes the character and returns to IDLE if the line is high, or goes to WAIT_HIGH if it is low. WAIT_HIGH returns to IDLE once a tick sees the line high.

Top module: `ovs_rx_queue`

## Requirements
- R1: After reset, data_ready is 0, overrun is 0 and rts is 1.
- R2: A character is taken least significant bit first. Its length is char_len+5 bits (char_len 0..3 gives 5..8 bits). Unused upper bits of rd_data read as 0.
- R3: A start is confirmed at the 8th tick after the tick on which the line was first seen low. If the line is high at that tick, nothing is received.
- R4: With par_en=1, one parity bit follows the data. par_odd=1 selects odd parity and par_odd=0 selects even parity. A mismatch sets rd_perr for that entry. With par_en=0, no parity bit is expected and rd_perr is 0.
- R5: A low stop bit on a character that is not a break stores the entry with rd_ferr=1. A new start is then accepted only after the line has been seen high.
- R6: A break is a frame in which every sampled bit, stop included, is low. It stores one entry with data 0x00, rd_brk=1, rd_ferr=1 and rd_perr=0, and no further entry is stored until the line returns high.
- R7: The queue holds 16 entries in arrival order. The head is shown without a strobe, and rd_en removes it. rd_en on an empty queue has no effect.
- R8: A character that completes while the queue is full is discarded and the stored entries are unchanged. overrun then goes to 1 and stays 1 until an rd_en strobe.
- R9: With rts_auto_en=1, trig_sel picks a threshold (0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14). rts goes to 0 once the fill level reaches the threshold and returns to 1 only when the queue is empty.
- R10: With rts_auto_en=0, rts is 1 regardless of the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle pulse, 16 per bit period |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| trig_sel | input | 2 | Flow-control threshold select |
| rts_auto_en | input | 1 | Enable automatic request-to-send |
| rd_en | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky data-lost flag |
| rts | output | 1 | Request-to-send, 1 means send allowed |

## Verification
Frames are sent with 8-bit and 5-bit lengths, so the length setting is shown to truncate rather than shift the data. Frames with 7 data bits are sent with correct and flipped parity in both polarities, which separates the even and odd checks. A low that lasts only three ticks, a low stop bit and a line held low for a whole frame each exercise a different exit from the frame engine: the false-start rejection, the framing error and the single break entry. Sixteen back-to-back frames plus a seventeenth test the threshold crossing, the overrun drop that keeps the oldest data, and the return of rts only when the queue is fully drained.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_CHK,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;
endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rxq_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_line,
    input  logic      tick16,
    input  logic [1:0] char_len,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      push,
    output rx_entry_t push_entry
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [2:0]       idx_q, idx_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic             par_q, par_d;
    logic             zero_q, zero_d;
    logic             push_d;
    rx_entry_t        entry_d;
    logic             centre;
    logic [2:0]       last_idx;

    assign centre   = tick16 && (cnt_q == LAST);
    assign last_idx = 3'(3'd4 + {1'b0, char_len});

    // next-state and output decisions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        data_d  = data_q;
        par_d   = par_q;
        zero_d  = zero_q;
        push_d  = 1'b0;
        entry_d = push_entry;
        unique case (state_q)
            ST_IDLE: begin
                if (tick16 && !rx_line) begin
                    state_d = ST_START_CHK;
                    cnt_d   = '0;
                end
            end
            ST_START_CHK: begin
                if (tick16) begin
                    if (cnt_q == MID) begin
                        if (rx_line) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_DATA;
                            cnt_d   = '0;
                            idx_d   = '0;
                            data_d  = '0;
                            zero_d  = 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (centre) begin
                    cnt_d         = '0;
                    data_d[idx_q] = rx_line;
                    zero_d        = zero_q && !rx_line;
                    if (idx_q == last_idx) state_d = par_en ? ST_PARITY : ST_STOP;
                    else                   idx_d   = idx_q + 1'b1;
                end else if (tick16) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PARITY: begin
                if (centre) begin
                    cnt_d   = '0;
                    par_d   = rx_line;
                    zero_d  = zero_q && !rx_line;
                    state_d = ST_STOP;
                end else if (tick16) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STOP: begin
                if (centre) begin
                    push_d = 1'b1;
                    if (zero_q && !rx_line) begin
                        entry_d = '{brk: 1'b1, ferr: 1'b1, perr: 1'b0, data: '0};
                    end else begin
                        entry_d.brk  = 1'b0;
                        entry_d.ferr = !rx_line;
                        entry_d.perr = par_en && ((^data_q ^ par_q) != par_odd);
                        entry_d.data = data_q;
                    end
                    state_d = rx_line ? ST_IDLE : ST_WAIT_HIGH;
                end else if (tick16) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WAIT_HIGH: begin
                if (tick16 && rx_line) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            idx_q      <= '0;
            data_q     <= '0;
            par_q      <= 1'b0;
            zero_q     <= 1'b0;
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            idx_q      <= idx_d;
            data_q     <= data_d;
            par_q      <= par_d;
            zero_q     <= zero_d;
            push       <= push_d;
            push_entry <= entry_d;
        end
    end

    p_false_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START_CHK && tick16 && cnt_q == MID && rx_line) |=> (state_q == ST_IDLE && !push));

    p_break_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_entry.brk) |-> (push_entry.ferr && !push_entry.perr && push_entry.data == '0));

    p_single_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    p_wait_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_HIGH && !rx_line) |=> (state_q == ST_WAIT_HIGH));
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  rx_entry_t     wr_entry,
    input  logic          rd_en,
    output rx_entry_t     rd_entry,
    output logic [CW-1:0] count,
    output logic          ovr_evt
);
    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, do_wr, do_rd;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign do_rd    = rd_en && !empty;
    assign do_wr    = wr_en && !full;
    assign ovr_evt  = wr_en && full;
    assign rd_entry = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (do_rd && !do_wr) count <= count - 1'b1;
        end
    end

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> (count == '0));

    p_full_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (count == CW'(DEPTH) && $stable(rp)));
endmodule

// File: rtl/ovs_rx_queue.sv
module ovs_rx_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_line,
    input  logic        tick16,
    input  logic [1:0]  char_len,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic [1:0]  trig_sel,
    input  logic        rts_auto_en,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    output logic        rd_perr,
    output logic        rd_ferr,
    output logic        rd_brk,
    output logic        data_ready,
    output logic        overrun,
    output logic        rts
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, ovr_evt;
    rx_entry_t     push_entry, head;
    logic [CW-1:0] fill, thr;
    logic          rts_q;

    rx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .push(push), .push_entry(push_entry)
    );

    rx_err_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_entry(push_entry),
        .rd_en(rd_en), .rd_entry(head), .count(fill), .ovr_evt(ovr_evt)
    );

    always_comb begin
        unique case (trig_sel)
            2'd0:    thr = CW'(1);
            2'd1:    thr = CW'(DEPTH / 4);
            2'd2:    thr = CW'(DEPTH / 2);
            default: thr = CW'(DEPTH - 2);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
            rts_q   <= 1'b1;
        end else begin
            if (ovr_evt)    overrun <= 1'b1;
            else if (rd_en) overrun <= 1'b0;
            if (!rts_auto_en)     rts_q <= 1'b1;
            else if (fill >= thr) rts_q <= 1'b0;
            else if (fill == '0)  rts_q <= 1'b1;
        end
    end

    assign rts        = rts_q;
    assign data_ready = (fill != '0);
    assign rd_data    = head.data;
    assign rd_perr    = head.perr;
    assign rd_ferr    = head.ferr;
    assign rd_brk     = head.brk;

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_en) |=> overrun);

    p_rts_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && fill >= thr) |=> (!rts || !rts_auto_en));

    p_rts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && !rts && fill != '0) |=> (!rts || !rts_auto_en));

    p_rts_manual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_auto_en |=> rts);
endmodule

// File: tb/tb_ovs_rx_queue.sv
module tb_ovs_rx_queue;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       rx_line = 1;
    logic       tick16 = 0;
    logic [1:0] char_len = 2'd3;
    logic       par_en = 0;
    logic       par_odd = 0;
    logic [1:0] trig_sel = 2'd3;
    logic       rts_auto_en = 0;
    logic       rd_en = 0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk, data_ready, overrun, rts;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    int tcnt = 0;

    logic [10:0] q[$];
    logic        ovr_exp = 0;
    logic        rts_exp = 1;

    ovs_rx_queue dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .trig_sel(trig_sel), .rts_auto_en(rts_auto_en), .rd_en(rd_en),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .data_ready(data_ready), .overrun(overrun), .rts(rts)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tcnt   = (tcnt + 1) % 4;
        tick16 = (tcnt == 3);
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic model_push(input logic [10:0] e);
        if (q.size() < 16) q.push_back(e);
        else ovr_exp = 1;
        if (rts_auto_en && q.size() >= thr_of(trig_sel)) rts_exp = 0;
    endtask

    task automatic hold(input logic v, input int n);
        @(negedge clk);
        rx_line = v;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input bit pflip, input logic stopv);
        int nb = 5 + int'(char_len);
        logic [7:0] dm = d & 8'((1 << nb) - 1);
        hold(0, 16);
        for (int i = 0; i < nb; i++) hold(d[i], 16);
        if (par_en) hold((^dm) ^ par_odd ^ pflip, 16);
        hold(stopv, 16);
        if (!stopv) hold(1, 16);
        hold(1, 4);
        model_push({1'b0, !stopv, par_en & pflip, dm});
    endtask

    task automatic frame_chk(input string req);
        @(negedge clk);
        chk(data_ready == (q.size() != 0), req, "data_ready", data_ready, q.size() != 0);
        chk(overrun == ovr_exp, req, "overrun", overrun, ovr_exp);
        chk(rts == rts_exp, req, "rts", rts, rts_exp);
    endtask

    task automatic read_one(input string req);
        @(negedge clk);
        chk(data_ready == (q.size() != 0), req, "data_ready before read", data_ready, q.size() != 0);
        if (q.size() != 0)
            chk({rd_brk, rd_ferr, rd_perr, rd_data} == q[0], req, "head entry",
                {rd_brk, rd_ferr, rd_perr, rd_data}, q[0]);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        if (q.size() != 0) void'(q.pop_front());
        ovr_exp = 0;
        if (q.size() == 0) rts_exp = 1;
        @(negedge clk);
        chk(overrun == ovr_exp, req, "overrun after read", overrun, ovr_exp);
        chk(rts == rts_exp, req, "rts after read", rts, rts_exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(data_ready == 0, "R1", "data_ready", data_ready, 0);
        chk(overrun == 0, "R1", "overrun", overrun, 0);
        chk(rts == 1, "R1", "rts", rts, 1);
        hold(1, 8);

        // R2 8-bit and 5-bit characters
        char_len = 2'd3;
        send_frame(8'hA5, 0, 1);
        frame_chk("R2");
        read_one("R2");
        char_len = 2'd0;
        send_frame(8'hF3, 0, 1);
        frame_chk("R2");
        read_one("R2");

        // R4 parity, 7 data bits, both polarities, good and bad
        char_len = 2'd2;
        par_en = 1;
        par_odd = 0;
        send_frame(8'h55, 0, 1);
        send_frame(8'h54, 1, 1);
        par_odd = 1;
        send_frame(8'h31, 0, 1);
        send_frame(8'h31, 1, 1);
        frame_chk("R4");
        for (int i = 0; i < 4; i++) read_one("R4");
        par_en = 0;
        char_len = 2'd3;

        // R3 false start: low for only three ticks
        hold(0, 3);
        hold(1, 40);
        frame_chk("R3");
        send_frame(8'h3C, 0, 1);
        frame_chk("R3");
        read_one("R3");

        // R5 framing error on a low stop bit
        send_frame(8'h81, 0, 0);
        frame_chk("R5");
        read_one("R5");

        // R6 break: line low for longer than a full frame
        hold(0, 16 * 14);
        hold(1, 20);
        model_push({1'b1, 1'b1, 1'b0, 8'h00});
        frame_chk("R6");
        read_one("R6");
        send_frame(8'h7E, 0, 1);
        frame_chk("R6");
        read_one("R6");

        // R7 read strobe on an empty queue has no effect
        read_one("R7");
        send_frame(8'h42, 0, 1);
        frame_chk("R7");
        read_one("R7");

        // R9 threshold of 1
        rts_auto_en = 1;
        trig_sel = 2'd0;
        send_frame(8'h11, 0, 1);
        frame_chk("R9");
        read_one("R9");

        // R9 threshold of 8 while filling, R8 overrun beyond 16
        trig_sel = 2'd2;
        for (int k = 0; k < 16; k++) begin
            send_frame(8'(k * 7 + 1), 0, 1);
            frame_chk("R9");
        end
        send_frame(8'hEE, 0, 1);
        frame_chk("R8");

        // R10 flow control off forces rts high
        rts_auto_en = 0;
        @(negedge clk);
        @(negedge clk);
        chk(rts == 1, "R10", "rts with auto off", rts, 1);
        rts_auto_en = 1;
        @(negedge clk);
        @(negedge clk);
        chk(rts == 0, "R9", "rts with auto back on", rts, 0);

        // R8 R7 drain in order; R9 rts back only at empty
        for (int k = 0; k < 16; k++) read_one("R8");
        chk(data_ready == 0, "R7", "data_ready after drain", data_ready, 0);
        chk(rts == 1, "R9", "rts after drain", rts, 1);

        finish_run();
    end
endmodule